// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Model

This block is a synthesizable behavioural model of a byte-wide parallel NOR flash. A host drives it with separate active-low chip-enable, write-enable and output-enable strobes, an address bus and a data bus. Commands are multi-write sequences. Each one opens with two unlock writes. A program sequence ends in a single address/data write. A sector-erase sequence ends in an erase confirm written to any address inside the target sector. Each accepted command starts a timed internal operation on a byte array. Every size and duration is a parameter. The defaults are small, so the model is quick to simulate: a 4 KiB array of four 1 KiB sectors. The full device setting is `ADDR_W=19`, `SECT_W=16`.

While an operation runs, the array cannot be read. A read returns a status byte instead. Bit 7 of that byte is the complement of the bit 7 being written. Bit 6 inverts on each new read. When the operation finishes, the model drops back to array reads without any command from the host.

A program operation can only clear bits, so the stored byte becomes the AND of the old byte and the written byte. An erase runs in three phases. It first drives every byte of the sector to 0x00, then waits a timed interval, then sets every byte of the sector to 0xFF. A supply-low input blocks every write while it is high.

Top module: `pflash_model`

## Requirements
- R1: After power-up every byte reads 0xFF. `dout` is 0x00 in any cycle after one in which `ce_n` or `oe_n` was high.
- R2: The sequence AA@0x555, 55@0x2AA, A0@0x555, then D@A starts a program of address A with data D. Only address bits [10:0] are compared for the unlock and command cycles.
- R3: A program stores the old byte AND D. A bit that is 0 stays 0.
- R4: A read while an operation is busy returns a status byte. Bit 7 is the inverse of D[7] for a program, and 0 for an erase. Bits 5..0 are 0.
- R5: Status bit 6 inverts on each read (a falling `oe_n` with `ce_n` low) during a busy operation. It does not change while idle, so repeated idle reads of one address return the same byte.
- R6: The sequence AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, then 30@S erases the sector that holds address S, leaving it all 0xFF. All other sectors keep their contents.
- R7: The model returns to array reads by itself when the operation ends. The array is never written while idle.
- R8: A write of 0xF0 at any step of an unfinished sequence, including the data step of a program, returns the decoder to idle without starting anything.
- R9: A write whose address or data does not match the expected step aborts the sequence. The steps that follow it then have no effect.
- R10: While `supply_low` is high, writes are ignored: no sequence step advances and no operation starts.
- R11: Writes that arrive while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of control state (array keeps its contents) |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; a write happens on its falling edge |
| oe_n | input | 1 | Active-low output enable; a read happens on its falling edge |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Registered read data or status byte |
| supply_low | input | 1 | High blocks all writes |

## Verification
A decoder stuck in the wrong step shows up at the ports on the next program attempt. A follow-up read of the target byte either keeps a value that should have dropped to the AND result, or loses a value that an aborted sequence should have left alone. Engine state errors show up within one operation time. A stuck busy flag keeps returning status bytes instead of array data. A wrong sector or offset counter leaves bytes that are not 0xFF inside the erased sector, or damages a neighbouring sector, and a full-array sweep after the erase exposes this. A toggle or polling bit error appears on the first two status reads after a command.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [2:0] {
    D_IDLE,
    D_UNL1,
    D_UNL2,
    D_PRGDAT,
    D_ESETUP,
    D_EUNL1,
    D_EUNL2
  } dec_st_t;

  typedef enum logic [2:0] {
    E_IDLE,
    E_PROG,
    E_PRE,
    E_WAIT,
    E_CLR
  } eng_st_t;

  localparam logic [7:0] K_UNLOCK_A    = 8'hAA;
  localparam logic [7:0] K_UNLOCK_B    = 8'h55;
  localparam logic [7:0] K_PROG        = 8'hA0;
  localparam logic [7:0] K_ERASE_SETUP = 8'h80;
  localparam logic [7:0] K_ERASE_GO    = 8'h30;
  localparam logic [7:0] K_ABORT       = 8'hF0;
  localparam logic [7:0] BYTE_ERASED   = 8'hFF;
  localparam logic [7:0] BYTE_ZERO     = 8'h00;

  localparam int          UNLK_AW  = 11;
  localparam logic [10:0] ADR_KEY1 = 11'h555;
  localparam logic [10:0] ADR_KEY2 = 11'h2AA;

endpackage

// File: rtl/pfl_array.sv
module pfl_array #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // erased at configuration, like a freshly shipped part
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/pfl_cmd_seq.sv
module pfl_cmd_seq
  import pfl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdat,
  output logic              start_prog,
  output logic              start_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  dec_st_t st;
  logic    at_key1, at_key2;

  assign at_key1 = (addr[UNLK_AW-1:0] == ADR_KEY1);
  assign at_key2 = (addr[UNLK_AW-1:0] == ADR_KEY2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= D_IDLE;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      if (wr_evt && !inhibit) begin
        if (wdat == K_ABORT) begin
          st <= D_IDLE;
        end else begin
          case (st)
            D_IDLE:   st <= (at_key1 && wdat == K_UNLOCK_A) ? D_UNL1 : D_IDLE;
            D_UNL1:   st <= (at_key2 && wdat == K_UNLOCK_B) ? D_UNL2 : D_IDLE;
            D_UNL2: begin
              if (at_key1 && wdat == K_PROG)             st <= D_PRGDAT;
              else if (at_key1 && wdat == K_ERASE_SETUP) st <= D_ESETUP;
              else                                       st <= D_IDLE;
            end
            D_PRGDAT: begin
              start_prog <= 1'b1;
              op_addr    <= addr;
              op_data    <= wdat;
              st         <= D_IDLE;
            end
            D_ESETUP: st <= (at_key1 && wdat == K_UNLOCK_A) ? D_EUNL1 : D_IDLE;
            D_EUNL1:  st <= (at_key2 && wdat == K_UNLOCK_B) ? D_EUNL2 : D_IDLE;
            D_EUNL2: begin
              if (wdat == K_ERASE_GO) begin
                start_erase <= 1'b1;
                op_addr     <= addr;
              end
              st <= D_IDLE;
            end
            default:  st <= D_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pfl_engine.sv
module pfl_engine
  import pfl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SECT_W    = 10,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [7:0]        rd_q,
  output logic              busy,
  output logic              is_erase,
  output logic              poll_bit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SEC_W   = ADDR_W - SECT_W;

  eng_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [SECT_W-1:0] ofs;
  logic [SEC_W-1:0]  sec_r;
  logic [ADDR_W-1:0] addr_r;
  logic [7:0]        data_r;

  assign busy     = (st != E_IDLE);
  assign is_erase = (st == E_PRE) || (st == E_WAIT) || (st == E_CLR);
  assign poll_bit = is_erase ? 1'b1 : data_r[7];

  always_comb begin
    mem_addr  = {sec_r, ofs};
    mem_we    = 1'b0;
    mem_wdata = BYTE_ERASED;
    case (st)
      E_PROG: begin
        mem_addr  = addr_r;
        mem_we    = (cnt == '0);
        mem_wdata = rd_q & data_r;
      end
      E_PRE: begin
        mem_we    = 1'b1;
        mem_wdata = BYTE_ZERO;
      end
      E_CLR: begin
        mem_we    = 1'b1;
        mem_wdata = BYTE_ERASED;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      cnt    <= '0;
      ofs    <= '0;
      sec_r  <= '0;
      addr_r <= '0;
      data_r <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (start_prog) begin
            addr_r <= op_addr;
            data_r <= op_data;
            cnt    <= CNT_W'(PROG_CYC - 1);
            st     <= E_PROG;
          end else if (start_erase) begin
            sec_r <= op_addr[ADDR_W-1:SECT_W];
            ofs   <= '0;
            st    <= E_PRE;
          end
        end
        E_PROG: begin
          if (cnt == '0) st <= E_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        E_PRE: begin
          ofs <= ofs + 1'b1;
          if (&ofs) begin
            cnt <= CNT_W'(ERASE_CYC - 1);
            st  <= E_WAIT;
          end
        end
        E_WAIT: begin
          if (cnt == '0) st <= E_CLR;
          else           cnt <= cnt - 1'b1;
        end
        E_CLR: begin
          ofs <= ofs + 1'b1;
          if (&ofs) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pflash_model.sv
module pflash_model #(
  parameter int ADDR_W    = 12,
  parameter int SECT_W    = 10,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  input  logic              supply_low
);
  logic              we_q, oe_q, tgl;
  logic              wr_evt, rd_evt;
  logic              start_prog, start_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              busy, is_erase, poll_bit;
  logic              mem_we;
  logic [ADDR_W-1:0] eng_addr, arr_raddr;
  logic [7:0]        mem_wdata, mem_q;

  assign wr_evt    = !ce_n && !we_n && we_q;
  assign rd_evt    = !ce_n && !oe_n && oe_q;
  assign arr_raddr = busy ? eng_addr : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
      tgl  <= 1'b0;
      dout <= '0;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
      if (rd_evt && busy) tgl <= ~tgl;
      if (ce_n || oe_n) dout <= '0;
      else if (busy)    dout <= {~poll_bit, tgl, 6'b0};
      else              dout <= mem_q;
    end
  end

  pfl_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_evt      (wr_evt),
    .inhibit     (supply_low || busy),
    .addr        (addr),
    .wdat        (din),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .op_addr     (op_addr),
    .op_data     (op_data)
  );

  pfl_engine #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .rd_q        (mem_q),
    .busy        (busy),
    .is_erase    (is_erase),
    .poll_bit    (poll_bit),
    .mem_we      (mem_we),
    .mem_addr    (eng_addr),
    .mem_wdata   (mem_wdata)
  );

  pfl_array #(.AW(ADDR_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (eng_addr),
    .wdata (mem_wdata),
    .raddr (arr_raddr),
    .q     (mem_q)
  );
endmodule

// File: rtl/pflash_model_chk.sv
module pflash_model_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       oe_n,
  input logic       supply_low,
  input logic       busy,
  input logic       is_erase,
  input logic       tgl,
  input logic       start_prog,
  input logic       start_erase,
  input logic       mem_we,
  input logic [7:0] dout
);
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n || oe_n) |-> (dout == 8'h00)); // R1

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(busy && is_erase && !ce_n && !oe_n) |-> (dout[7] == 1'b0 && dout[5:0] == 6'b0)); // R4

  AST_TGL_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tgl)); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R7

  AST_LOW_SUPPLY_NO_START: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !(start_prog || start_erase)); // R10

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(start_prog || start_erase)); // R11
endmodule

bind pflash_model pflash_model_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .supply_low  (supply_low),
  .busy        (busy),
  .is_erase    (is_erase),
  .tgl         (tgl),
  .start_prog  (start_prog),
  .start_erase (start_erase),
  .mem_we      (mem_we),
  .dout        (dout)
);

// File: tb/pflash_model_bench.sv
module pflash_model_bench;
  localparam int AW    = 12;
  localparam int SW    = 10;
  localparam int PC    = 16;
  localparam int EC    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  pflash_model #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_pflash_model (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .supply_low(supply_low)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    d = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(12'h555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    unlock();
    wr(12'h555, 8'h80);
    unlock();
    wr(a, 8'h30);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // program with status checks during busy and a readback after
  task automatic prog_check(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] s1, s2, v1, v2;
    prog(a, d);
    model[a] = model[a] & d;
    rd(a, s1);
    rd(a, s2);
    chk("R4 prog DQ7", {7'b0, s1[7]}, {7'b0, ~d[7]});
    chk("R4 low bits", {2'b0, s1[5:0]}, 8'h00);
    chk("R5 toggle", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    idle(PC + 10);
    rd(a, v1);
    chk("R2/R3/R7 readback", v1, model[a]);
    rd(a, v2);
    chk("R5 idle stable", v2, v1);
  endtask

  initial begin
    logic [7:0] v, s1, s2;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    idle(4);
    rst = 1'b0;
    idle(2);
    chk("R1 dout after reset", dout, 8'h00);

    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), v);
      chk("R1 erased", v, 8'hFF);
    end
    idle(1);
    chk("R1 dout idle", dout, 8'h00);

    // R2 / R3: program and AND behaviour
    prog_check(12'h010, 8'h5A);
    prog_check(12'h010, 8'h0F);
    prog_check(12'h9AB, 8'h3C);
    prog_check(12'h555, 8'h81);
    prog_check(12'h7FF, 8'h00);
    prog_check(12'h400, 8'hC3);
    prog_check(12'h3FF, 8'h7E);

    // R8: abort with 0xF0 after unlock, and at the data step
    unlock();
    wr(12'h000, 8'hF0);
    wr(12'h555, 8'hA0);
    wr(12'h020, 8'h00);
    idle(PC + 10);
    rd(12'h020, v);
    chk("R8 abort after unlock", v, model[12'h020]);
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h021, 8'hF0);
    idle(PC + 10);
    rd(12'h021, v);
    chk("R8 abort at data step", v, model[12'h021]);

    // R9: wrong address, wrong command byte
    wr(12'h555, 8'hAA);
    wr(12'h2AB, 8'h55);
    wr(12'h555, 8'hA0);
    wr(12'h030, 8'h00);
    idle(PC + 10);
    rd(12'h030, v);
    chk("R9 wrong unlock addr", v, model[12'h030]);
    unlock();
    wr(12'h555, 8'h90);
    wr(12'h031, 8'h00);
    idle(PC + 10);
    rd(12'h031, v);
    chk("R9 wrong command", v, model[12'h031]);
    prog_check(12'h032, 8'h11);

    // R10: supply low
    supply_low = 1'b1;
    prog(12'h050, 8'h00);
    rd(12'h050, v);
    chk("R10 no busy under low supply", v, model[12'h050]);
    unlock();
    supply_low = 1'b0;
    wr(12'h555, 8'hA0);
    wr(12'h051, 8'h00);
    idle(PC + 10);
    rd(12'h051, v);
    chk("R10 inhibited unlock", v, model[12'h051]);

    // R11: writes during busy
    prog(12'h040, 8'h0F);
    model[12'h040] = model[12'h040] & 8'h0F;
    prog(12'h041, 8'h00);
    idle(PC + 10);
    rd(12'h041, v);
    chk("R11 busy write ignored", v, model[12'h041]);
    rd(12'h040, v);
    chk("R11 first program done", v, model[12'h040]);

    // R6: erase sector 1 via an address inside it
    erase(12'h5A5);
    for (int i = 12'h400; i < 12'h800; i++) model[i] = 8'hFF;
    rd(12'h400, s1);
    rd(12'h400, s2);
    chk("R4 erase DQ7", {s1[7], s1[5:0]}, 7'b0);
    chk("R5 erase toggle", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    idle(2 * (1 << SW) + EC + 40);
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), v);
      chk("R6 sweep after erase", v, model[a]);
    end
    prog_check(12'h4AA, 8'h66);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule